// File: doc/BRIEF.md
# Variable-Latency In-Order Pipeline Sequencer

This block is a cycle-accurate timing model of a four-stage in-order pipeline (Fetch, Decode, Execute, Write Back). No operands or opcodes pass through it. Each instruction arrives on a valid/ready input as a descriptor that holds a tag and its own cycle count for each stage. The block steps every instruction through the stages in order. It holds an instruction in a stage when the next stage is still busy, and it reports each retirement with the tag and the cycle number of the final Write Back cycle.

The sequencer is meant for performance studies and for scoreboards that need exact retirement timing when stage latency varies per instruction. A running cycle counter numbers the cycles in which the pipeline holds work. The cycle in which the first instruction occupies Fetch is cycle 1. A drained flag tells the environment when nothing is left in flight or waiting.

Top module: `vlp_seq`

## Requirements
- R1: Every instruction occupies Fetch, Decode, Execute and Write Back in that order, each for at least its stated number of cycles. A lone instruction with durations Fetch 1, Decode 2, Execute 1, Write Back 1 accepted into an empty pipeline retires at cycle 5.
- R2: The descriptor input `in_durs` packs four 4-bit durations: bits 3:0 for Fetch, 7:4 for Decode, 11:8 for Execute and 15:12 for Write Back. A field value of 0 behaves as 1. A lone descriptor of 0x0003 retires at cycle 6.
- R3: A stage holds at most one instruction. An instruction that has finished a stage while the next stage is busy stays where it is, keeping its stage busy, until the next stage frees up.
- R4: `in_ready` is high only when Fetch is empty or its occupant leaves at the coming edge. An accepted descriptor occupies Fetch from the next cycle on.
- R5: A retirement raises `ret_valid` for exactly one cycle, in the cycle after the last Write Back cycle, with that instruction's tag and the cycle number of its last Write Back cycle.
- R6: `cycle_cnt` is 0 after reset. It advances by one at each edge after which some stage holds an instruction, and it stays frozen while the pipeline is empty.
- R7: `drained` is high exactly when `in_valid` is low and all four stages are empty.
- R8: With every duration equal to 1 and descriptors presented back to back, the pipeline retires one instruction per cycle, the k-th at cycle k+3.
- R9: Five descriptors with durations (F,D,E,WB) of (1,2,1,1), (1,2,2,1), (2,1,3,2), (1,3,2,1) and (1,2,1,2), presented back to back, retire in order at cycles 5, 8, 12, 13 and 15.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| in_valid | input | 1 | Descriptor present |
| in_ready | output | 1 | Fetch can take a descriptor at the coming edge |
| in_tag | input | TAG_W (8) | Instruction tag |
| in_durs | input | 4*DUR_W (16) | Per-stage durations, Fetch in the low field |
| ret_valid | output | 1 | One-cycle retirement pulse |
| ret_tag | output | TAG_W (8) | Tag of the retiring instruction |
| ret_cycle | output | CYC_W (16) | Cycle number of its last Write Back cycle |
| cycle_cnt | output | CYC_W (16) | Current cycle number |
| stage_busy | output | 4 | Occupancy, bit 0 Fetch through bit 3 Write Back |
| drained | output | 1 | No input pending and all stages empty |

## Verification
The bench's main target is the stall that ripples backwards when a long stage downstream blocks an instruction that has already finished its own stage. A design that drops the waiting instruction, overwrites the busy stage, or lets it advance one cycle early misplaces the reference retirements at 8, 12, 13 and 15. A zero-duration field is also checked: a design that loads 0 into a down-counter would wrap to 15 cycles instead of 1. The unit-duration stream checks that a stage can be vacated and refilled at the same edge. A design without that would insert a bubble and slip to one retirement every two cycles. The bench also checks that the counter freezes during the idle tail and that `in_ready` drops while a multi-cycle Fetch is in progress.

// File: rtl/vlp_pkg.sv
package vlp_pkg;
  localparam int NUM_STAGES = 4;

  typedef enum logic [1:0] {
    ST_FETCH  = 2'd0,
    ST_DECODE = 2'd1,
    ST_EXEC   = 2'd2,
    ST_WB     = 2'd3
  } stage_e;
endpackage

// File: rtl/vlp_stage.sv
module vlp_stage #(
  parameter int IDX   = 0,
  parameter int NS    = 4,
  parameter int DUR_W = 4,
  parameter int TAG_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [TAG_W-1:0]  tag_i,
  input  logic [NS*DUR_W-1:0] durs_i,
  input  logic              leave_i,
  output logic              valid_o,
  output logic              done_o,
  output logic [TAG_W-1:0]  tag_o,
  output logic [NS*DUR_W-1:0] durs_o
);
  localparam logic [DUR_W-1:0] ONE = DUR_W'(1);

  logic               valid_q, valid_d;
  logic [DUR_W-1:0]   cnt_q, cnt_d;
  logic [TAG_W-1:0]   tag_q, tag_d;
  logic [NS*DUR_W-1:0] durs_q, durs_d;
  logic [DUR_W-1:0]   dur_sel, dur_load;
  logic               upd_en;

  // a zero field counts as a single cycle
  assign dur_sel  = durs_i[IDX*DUR_W +: DUR_W];
  assign dur_load = (dur_sel == '0) ? ONE : dur_sel;
  assign upd_en   = load_i | valid_q;

  always_comb begin
    valid_d = valid_q;
    cnt_d   = cnt_q;
    tag_d   = tag_q;
    durs_d  = durs_q;
    if (load_i) begin
      valid_d = 1'b1;
      cnt_d   = dur_load;
      tag_d   = tag_i;
      durs_d  = durs_i;
    end else if (valid_q) begin
      if (leave_i)
        valid_d = 1'b0;
      else if (cnt_q != ONE)
        cnt_d = cnt_q - ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      cnt_q   <= '0;
      tag_q   <= '0;
      durs_q  <= '0;
    end else begin
      valid_q <= valid_d;
      if (upd_en) begin
        cnt_q  <= cnt_d;
        tag_q  <= tag_d;
        durs_q <= durs_d;
      end
    end
  end

  assign valid_o = valid_q;
  assign done_o  = valid_q && (cnt_q == ONE);
  assign tag_o   = tag_q;
  assign durs_o  = durs_q;
endmodule

// File: rtl/vlp_cyc_ctr.sv
module vlp_cyc_ctr #(
  parameter int CYC_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv_i,
  output logic [CYC_W-1:0] count_o
);
  logic [CYC_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q + CYC_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (adv_i)
      cnt_q <= cnt_d;
  end

  assign count_o = cnt_q;
endmodule

// File: rtl/vlp_retire.sv
module vlp_retire #(
  parameter int TAG_W = 8,
  parameter int CYC_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fire_i,
  input  logic [TAG_W-1:0] tag_i,
  input  logic [CYC_W-1:0] cycle_i,
  output logic             valid_o,
  output logic [TAG_W-1:0] tag_o,
  output logic [CYC_W-1:0] cycle_o
);
  logic             vld_q;
  logic [TAG_W-1:0] tag_q;
  logic [CYC_W-1:0] cyc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      tag_q <= '0;
      cyc_q <= '0;
    end else begin
      vld_q <= fire_i;
      if (fire_i) begin
        tag_q <= tag_i;
        cyc_q <= cycle_i;
      end
    end
  end

  assign valid_o = vld_q;
  assign tag_o   = tag_q;
  assign cycle_o = cyc_q;
endmodule

// File: rtl/vlp_seq.sv
module vlp_seq
  import vlp_pkg::*;
#(
  parameter int DUR_W = 4,
  parameter int TAG_W = 8,
  parameter int CYC_W = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        in_valid,
  output logic                        in_ready,
  input  logic [TAG_W-1:0]            in_tag,
  input  logic [NUM_STAGES*DUR_W-1:0] in_durs,
  output logic                        ret_valid,
  output logic [TAG_W-1:0]            ret_tag,
  output logic [CYC_W-1:0]            ret_cycle,
  output logic [CYC_W-1:0]            cycle_cnt,
  output logic [NUM_STAGES-1:0]       stage_busy,
  output logic                        drained
);
  localparam int NS = NUM_STAGES;
  localparam int DW_ALL = NS * DUR_W;
  localparam int LAST = int'(ST_WB);

  logic [NS-1:0]     busy, done, go, load;
  logic [TAG_W-1:0]  tag_arr  [NS];
  logic [DW_ALL-1:0] durs_arr [NS];
  logic              in_fire, occ_next;

  // resolve advances from Write Back back to Fetch
  always_comb begin
    go[LAST] = done[LAST];
    for (int s = LAST - 1; s >= 0; s--)
      go[s] = done[s] && (!busy[s+1] || go[s+1]);
  end

  assign in_ready = !busy[int'(ST_FETCH)] || go[int'(ST_FETCH)];
  assign in_fire  = in_valid && in_ready;

  genvar g;
  generate
    for (g = 0; g < NS; g++) begin : g_stage
      logic [TAG_W-1:0]  tag_in;
      logic [DW_ALL-1:0] durs_in;
      if (g == 0) begin : g_head
        assign load[g]  = in_fire;
        assign tag_in   = in_tag;
        assign durs_in  = in_durs;
      end else begin : g_body
        assign load[g]  = go[g-1];
        assign tag_in   = tag_arr[g-1];
        assign durs_in  = durs_arr[g-1];
      end
      vlp_stage #(
        .IDX   (g),
        .NS    (NS),
        .DUR_W (DUR_W),
        .TAG_W (TAG_W)
      ) u_stage (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (load[g]),
        .tag_i   (tag_in),
        .durs_i  (durs_in),
        .leave_i (go[g]),
        .valid_o (busy[g]),
        .done_o  (done[g]),
        .tag_o   (tag_arr[g]),
        .durs_o  (durs_arr[g])
      );
    end
  endgenerate

  // some stage will be occupied after this edge
  assign occ_next = in_fire || (|(busy & ~go)) || (|go[LAST-1:0]);

  vlp_cyc_ctr #(.CYC_W(CYC_W)) u_ctr (
    .clk     (clk),
    .rst_n   (rst_n),
    .adv_i   (occ_next),
    .count_o (cycle_cnt)
  );

  vlp_retire #(.TAG_W(TAG_W), .CYC_W(CYC_W)) u_ret (
    .clk     (clk),
    .rst_n   (rst_n),
    .fire_i  (go[LAST]),
    .tag_i   (tag_arr[LAST]),
    .cycle_i (cycle_cnt),
    .valid_o (ret_valid),
    .tag_o   (ret_tag),
    .cycle_o (ret_cycle)
  );

  assign stage_busy = busy;
  assign drained    = !in_valid && (busy == '0);
endmodule

// File: rtl/vlp_seq_chk.sv
module vlp_seq_chk #(
  parameter int NS    = 4,
  parameter int CYC_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic [NS-1:0]    stage_busy,
  input logic             ret_valid,
  input logic [CYC_W-1:0] cycle_cnt,
  input logic             drained
);
  p_cycle_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cycle_cnt != $past(cycle_cnt)) |-> (cycle_cnt == $past(cycle_cnt) + CYC_W'(1)));

  p_idle_freeze_r6: assert property (@(posedge clk) disable iff (!rst_n)
    drained |=> $stable(cycle_cnt));

  p_accept_fetch_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> stage_busy[0]);

  p_fetch_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (stage_busy[0] && !in_ready) |=> stage_busy[0]);

  p_ret_from_wb_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ret_valid |-> $past(stage_busy[NS-1]));
endmodule

bind vlp_seq vlp_seq_chk #(.NS(vlp_pkg::NUM_STAGES), .CYC_W(CYC_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .stage_busy (stage_busy),
  .ret_valid  (ret_valid),
  .cycle_cnt  (cycle_cnt),
  .drained    (drained)
);

// File: tb/vlp_seq_tb_top.sv
`timescale 1ns/1ps
module vlp_seq_tb_top;
  localparam int TW = 8;
  localparam int CW = 16;
  localparam int WD_LIMIT = 20000;
  localparam int NREF = 5;
  localparam logic [15:0] REF_DURS [NREF] = '{16'h1121, 16'h1221, 16'h2312, 16'h1231, 16'h2121};
  localparam int          REF_CYC  [NREF] = '{5, 8, 12, 13, 15};

  logic          clk, rst_n, in_valid, in_ready, ret_valid, drained;
  logic [TW-1:0] in_tag, ret_tag;
  logic [15:0]   in_durs;
  logic [CW-1:0] ret_cycle, cycle_cnt;
  logic [3:0]    stage_busy;

  int checks = 0;
  int errors = 0;
  int tb_cyc = 0;
  int ret_n  = 0;
  logic [TW-1:0] got_tag [32];
  int            got_cyc [32];

  vlp_seq dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_tag(in_tag), .in_durs(in_durs), .ret_valid(ret_valid), .ret_tag(ret_tag),
    .ret_cycle(ret_cycle), .cycle_cnt(cycle_cnt), .stage_busy(stage_busy),
    .drained(drained)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  always @(posedge clk) begin
    tb_cyc <= tb_cyc + 1;
    if (tb_cyc == WD_LIMIT) begin
      $display("FAIL watchdog: actual %0d cycles, expected fewer", tb_cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks + 1, errors + 1);
      $finish;
    end
  end

  always @(negedge clk) begin
    if (rst_n && ret_valid && ret_n < 32) begin
      got_tag[ret_n] = ret_tag;
      got_cyc[ret_n] = int'(ret_cycle);
      ret_n = ret_n + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    in_valid = 1'b0; in_tag = '0; in_durs = '0;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic push(input logic [TW-1:0] t, input logic [15:0] d);
    in_valid = 1'b1; in_tag = t; in_durs = d;
    #1;
    while (!in_ready) begin @(negedge clk); #1; end
    @(negedge clk);
  endtask

  task automatic wait_drain();
    in_valid = 1'b0;
    #1;
    while (!drained) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    int base;
    int frz;
    do_reset();
    // reset state
    chk(in_ready == 1'b1, "R4", "ready after reset", in_ready, 1);
    chk(ret_valid == 1'b0, "R5", "no pulse after reset", ret_valid, 0);
    chk(cycle_cnt == 0, "R6", "counter after reset", cycle_cnt, 0);
    chk(drained == 1'b1, "R7", "drained after reset", drained, 1);
    chk(stage_busy == 4'b0, "R3", "empty after reset", stage_busy, 0);

    // reference table, back to back (R1 first entry, R3 stalls, R9 totals)
    base = ret_n;
    for (int i = 0; i < NREF; i++) push(TW'(i + 1), REF_DURS[i]);
    wait_drain();
    chk(ret_n - base == NREF, "R9", "retire count", ret_n - base, NREF);
    for (int i = 0; i < NREF; i++) begin
      chk(got_tag[base+i] == TW'(i + 1), "R9", "retire order tag", got_tag[base+i], i + 1);
      chk(got_cyc[base+i] == REF_CYC[i], (i == 0) ? "R1" : "R3", "retire cycle",
          got_cyc[base+i], REF_CYC[i]);
    end
    frz = int'(cycle_cnt);
    repeat (5) @(negedge clk);
    chk(cycle_cnt == 15, "R6", "counter frozen while idle", cycle_cnt, 15);
    chk(int'(cycle_cnt) == frz, "R6", "counter stable", cycle_cnt, frz);
    chk(drained == 1'b1, "R7", "drained after run", drained, 1);

    // zero fields and multi-cycle fetch
    do_reset();
    base = ret_n;
    in_valid = 1'b1; in_tag = 8'hA5; in_durs = 16'h0003;
    #1;
    chk(drained == 1'b0, "R7", "not drained while input pending", drained, 0);
    push(8'hA5, 16'h0003);
    in_valid = 1'b0;
    #1;
    chk(stage_busy == 4'b0001, "R4", "fetch occupied after accept", stage_busy, 1);
    chk(in_ready == 1'b0, "R4", "ready low during long fetch", in_ready, 0);
    chk(cycle_cnt == 1, "R6", "first occupied cycle is 1", cycle_cnt, 1);
    wait_drain();
    chk(ret_n - base == 1, "R5", "single pulse", ret_n - base, 1);
    chk(got_tag[base] == 8'hA5, "R5", "retire tag", got_tag[base], 8'hA5);
    chk(got_cyc[base] == 6, "R2", "zero fields as one cycle", got_cyc[base], 6);
    chk(ret_valid == 1'b0, "R5", "pulse ended", ret_valid, 0);

    // unit durations stream
    do_reset();
    base = ret_n;
    for (int i = 0; i < 6; i++) push(TW'(8'h20 + i), 16'h1111);
    wait_drain();
    chk(ret_n - base == 6, "R8", "stream retire count", ret_n - base, 6);
    for (int i = 0; i < 6; i++) begin
      chk(got_cyc[base+i] == i + 4, "R8", "one per cycle", got_cyc[base+i], i + 4);
      chk(got_tag[base+i] == TW'(8'h20 + i), "R8", "stream tag", got_tag[base+i], 8'h20 + i);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule